// File: doc/BRIEF.md
# SPI Command/Register Access Slave

This block is a serial register port for a host processor. The host drives a four-wire SPI bus in mode 0 (clock idle low, data sampled on the rising edge). Each access is one frame of exactly two bytes with chip select held low. The first byte is a command that names a direction, one of four register modules and a register index within that module. The second byte carries the write data, or carries the read data back on MISO within the same frame.

The bus pins are brought into the system clock domain through multi-flop synchronizers. The block detects SCLK edges there, so the system clock has to run at least eight times faster than SCLK. Behind the frame engine sit three register modules: system control, I/O control and streaming control. Each module holds a few configuration fields that drive output ports directly, reads back status inputs, and reports a build-time version byte. A frame that ends early writes nothing. A frame aimed at the reserved module or at an unused index reads zero and changes nothing.

Top module: `cmdreg_spi_slave`

## Requirements
- R1: MOSI is sampled MSB first on rising SCLK while CS_n is low. MISO is 0 while CS_n is high and throughout the command byte.
- R2: Command byte encoding is as follows. Bit 7 is the write flag (1 = write, 0 = read). Bits 6:5 select the module: 0 = system, 1 = I/O, 2 = streaming, 3 = reserved. Bits 4:0 are the register index. A write takes effect only after the 16th rising SCLK edge of the frame.
- R3: During the second byte, MISO shifts out the selected register MSB first. It changes after falling SCLK edges, so the first bit is valid before the first rising edge of that byte.
- R4: If CS_n rises before 16 bits have been received, no register is written.
- R5: Index 0 of modules 0, 1 and 2 reads that module's version parameter. System index 1 reads the system version parameter. System index 2 reads the manufacturer ID parameter.
- R6: System module registers:
  - Index 3 reads the error status input, and writes to it are ignored.
  - Index 5 is a read/write debug field in bits 2:0: bit 0 drives FIFO-push debug, bit 1 drives FIFO-pull debug and bit 2 drives streaming debug. Bits 7:3 read as 0.
  - Index 6 is an 8-bit read/write transmit sample gap.
- R7: I/O index 1 holds a debug mode in bits 1:0 and an RF path mode in bits 4:2. A write whose RF path value is 6 or 7 updates the debug mode but keeps the previous RF path. Bits 7:5 read as 0.
- R8: I/O index 2 reads {button, cfg[3:0], 0, led1, led0} from bit 7 down to bit 0. A write changes only the two LED bits.
- R9: I/O index 3 is an 8-bit read/write expansion-port direction register. I/O index 4 is an 8-bit read/write expansion-port value register.
- R10: Streaming index 1 reads the FIFO status input and ignores writes. Index 2 is a channel select and index 3 is a direction select; each is held in bit 0, and the other bits read as 0.
- R11: Reads of module 3 or of any undefined index return 0x00. Writes to them change no register.
- R12: After reset every register and MISO is 0.
- R13: Clock edges after the 16th in a frame cause no further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from host (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data |
| err_status_i | input | 8 | Error status bits returned by system index 3 |
| dbg_fifo_push_o | output | 1 | FIFO-push debug enable |
| dbg_fifo_pull_o | output | 1 | FIFO-pull debug enable |
| dbg_stream_o | output | 1 | Streaming-interface debug enable |
| tx_gap_o | output | 8 | Transmit sample gap |
| io_dbg_mode_o | output | 2 | I/O debug mode |
| rf_path_o | output | 3 | RF path mode, always 0 to 5 |
| led_o | output | 2 | LED drive, bit 0 = LED0 |
| cfg_i | input | 4 | Configuration strap input |
| button_i | input | 1 | Button input |
| exp_dir_o | output | 8 | Expansion-port direction |
| exp_val_o | output | 8 | Expansion-port value |
| fifo_status_i | input | 8 | FIFO status returned by streaming index 1 |
| chan_sel_o | output | 1 | Streaming channel select |
| dir_sel_o | output | 1 | Streaming direction select |

## Verification
The bench builds the block with three synchronizer stages instead of the default two. This pushes edge-detect latency close to the eight-clock SCLK half period the bench uses, so the first MISO bit of the data byte is checked where the margin is tight. Each of the five version parameters gets its own distinct value. A read that lands in the wrong module, or decodes the wrong index, therefore returns a recognisably wrong byte rather than a coincidental match.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 5;

    typedef enum logic [1:0] {
        MOD_SYS    = 2'd0,
        MOD_IO     = 2'd1,
        MOD_STREAM = 2'd2,
        MOD_RSVD   = 2'd3
    } mod_e;

    typedef struct packed {
        logic             wr;
        mod_e             module_sel;
        logic [IDX_W-1:0] idx;
    } cmd_t;

    localparam logic [IDX_W-1:0] IDX_MODVER     = 5'd0;
    localparam logic [IDX_W-1:0] SYS_IDX_SYSVER = 5'd1;
    localparam logic [IDX_W-1:0] SYS_IDX_MANUF  = 5'd2;
    localparam logic [IDX_W-1:0] SYS_IDX_ERR    = 5'd3;
    localparam logic [IDX_W-1:0] SYS_IDX_DBG    = 5'd5;
    localparam logic [IDX_W-1:0] SYS_IDX_GAP    = 5'd6;
    localparam logic [IDX_W-1:0] IO_IDX_MODE    = 5'd1;
    localparam logic [IDX_W-1:0] IO_IDX_DIG     = 5'd2;
    localparam logic [IDX_W-1:0] IO_IDX_XDIR    = 5'd3;
    localparam logic [IDX_W-1:0] IO_IDX_XVAL    = 5'd4;
    localparam logic [IDX_W-1:0] ST_IDX_FIFO    = 5'd1;
    localparam logic [IDX_W-1:0] ST_IDX_CHAN    = 5'd2;
    localparam logic [IDX_W-1:0] ST_IDX_DIR     = 5'd3;

    localparam logic [2:0] RF_PATH_MAX = 3'd5;

    function automatic logic rf_path_legal(input logic [2:0] v);
        return v <= RF_PATH_MAX;
    endfunction

endpackage

// File: rtl/cmdreg_sync.sv
module cmdreg_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RST_VAL;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cmdreg_spi_frame.sv
module cmdreg_spi_frame
    import cmdreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data_i,
    output cmd_t              cmd_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              miso_o
);
    localparam int FRAME_BITS = 2 * DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_CMD_DONE = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);

    logic              sclk_d;
    logic              sclk_rise, sclk_fall, active;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh, tx_sh, rx_next, wdata_q;
    cmd_t              cmd_q;
    logic              wr_q;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign active    = ~cs_n_s;
    assign rx_next   = {rx_sh[DATA_W-2:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            cmd_q   <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            wr_q   <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else begin
                if (sclk_rise && bit_cnt < CNT_FULL) begin
                    rx_sh   <= rx_next;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_CMD_DONE - 1'b1) cmd_q <= cmd_t'(rx_next);
                    if (bit_cnt == CNT_FULL - 1'b1) begin
                        wdata_q <= rx_next;
                        wr_q    <= cmd_q.wr;
                    end
                end
                if (sclk_fall) begin
                    if (bit_cnt == CNT_CMD_DONE)
                        tx_sh <= rd_data_i;
                    else if (bit_cnt > CNT_CMD_DONE && bit_cnt < CNT_FULL)
                        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                    else
                        tx_sh <= '0;
                end
            end
        end
    end

    assign cmd_o   = cmd_q;
    assign wr_o    = wr_q;
    assign wdata_o = wdata_q;
    assign miso_o  = tx_sh[DATA_W-1];

    // R1: MISO returns to 0 once chip select is seen high
    a_r1_miso_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !miso_o);
    // R4: a write strobe only follows a complete 16-bit frame
    a_r4_full_frame_only: assert property (@(posedge clk) disable iff (rst)
        wr_o |-> bit_cnt == CNT_FULL);
    // R13: at most one write strobe per frame
    a_r13_single_write: assert property (@(posedge clk) disable iff (rst)
        wr_o |=> !wr_o);
endmodule

// File: rtl/cmdreg_sys_regs.sv
module cmdreg_sys_regs
    import cmdreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] MOD_VERSION = 8'h01,
    parameter logic [DATA_W-1:0] SYS_VERSION = 8'h01,
    parameter logic [DATA_W-1:0] MANUF_ID    = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] err_status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [2:0]        dbg_o,
    output logic [DATA_W-1:0] gap_o
);
    logic [2:0]        dbg_q;
    logic [DATA_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_q <= '0;
            gap_q <= '0;
        end else if (we_i) begin
            if (idx_i == SYS_IDX_DBG) dbg_q <= wdata_i[2:0];
            if (idx_i == SYS_IDX_GAP) gap_q <= wdata_i;
        end
    end

    always_comb begin
        unique case (idx_i)
            IDX_MODVER:     rdata_o = MOD_VERSION;
            SYS_IDX_SYSVER: rdata_o = SYS_VERSION;
            SYS_IDX_MANUF:  rdata_o = MANUF_ID;
            SYS_IDX_ERR:    rdata_o = err_status_i;
            SYS_IDX_DBG:    rdata_o = {{(DATA_W-3){1'b0}}, dbg_q};
            SYS_IDX_GAP:    rdata_o = gap_q;
            default:        rdata_o = '0;
        endcase
    end

    assign dbg_o = dbg_q;
    assign gap_o = gap_q;

    // R6: the sample gap only moves on a write to its own index
    a_r6_gap_hold: assert property (@(posedge clk) disable iff (rst)
        !(we_i && idx_i == SYS_IDX_GAP) |=> $stable(gap_q));
    // R6: the debug field only moves on a write to its own index
    a_r6_dbg_hold: assert property (@(posedge clk) disable iff (rst)
        !(we_i && idx_i == SYS_IDX_DBG) |=> $stable(dbg_q));
endmodule

// File: rtl/cmdreg_io_regs.sv
module cmdreg_io_regs
    import cmdreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] MOD_VERSION = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [3:0]        cfg_i,
    input  logic              button_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [1:0]        dbg_mode_o,
    output logic [2:0]        rf_path_o,
    output logic [1:0]        led_o,
    output logic [DATA_W-1:0] xdir_o,
    output logic [DATA_W-1:0] xval_o
);
    logic [1:0]        dbg_mode_q;
    logic [2:0]        rf_q;
    logic [1:0]        led_q;
    logic [DATA_W-1:0] xdir_q, xval_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_mode_q <= '0;
            rf_q       <= '0;
            led_q      <= '0;
            xdir_q     <= '0;
            xval_q     <= '0;
        end else if (we_i) begin
            unique case (idx_i)
                IO_IDX_MODE: begin
                    dbg_mode_q <= wdata_i[1:0];
                    if (rf_path_legal(wdata_i[4:2])) rf_q <= wdata_i[4:2];
                end
                IO_IDX_DIG:  led_q  <= wdata_i[1:0];
                IO_IDX_XDIR: xdir_q <= wdata_i;
                IO_IDX_XVAL: xval_q <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (idx_i)
            IDX_MODVER:  rdata_o = MOD_VERSION;
            IO_IDX_MODE: rdata_o = {3'b000, rf_q, dbg_mode_q};
            IO_IDX_DIG:  rdata_o = {button_i, cfg_i, 1'b0, led_q};
            IO_IDX_XDIR: rdata_o = xdir_q;
            IO_IDX_XVAL: rdata_o = xval_q;
            default:     rdata_o = '0;
        endcase
    end

    assign dbg_mode_o = dbg_mode_q;
    assign rf_path_o  = rf_q;
    assign led_o      = led_q;
    assign xdir_o     = xdir_q;
    assign xval_o     = xval_q;

    // R7: the RF path never holds an illegal code
    a_r7_rf_legal: assert property (@(posedge clk) disable iff (rst)
        rf_q <= RF_PATH_MAX);
    // R9: the expansion value only moves on a write to its own index
    a_r9_xval_hold: assert property (@(posedge clk) disable iff (rst)
        !(we_i && idx_i == IO_IDX_XVAL) |=> $stable(xval_q));
    // R8: the LEDs only move on a write to the digital register
    a_r8_led_hold: assert property (@(posedge clk) disable iff (rst)
        !(we_i && idx_i == IO_IDX_DIG) |=> $stable(led_q));
endmodule

// File: rtl/cmdreg_stream_regs.sv
module cmdreg_stream_regs
    import cmdreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] MOD_VERSION = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              wbit0_i,
    input  logic [DATA_W-1:0] fifo_status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              chan_o,
    output logic              dir_o
);
    logic chan_q, dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= 1'b0;
            dir_q  <= 1'b0;
        end else if (we_i) begin
            if (idx_i == ST_IDX_CHAN) chan_q <= wbit0_i;
            if (idx_i == ST_IDX_DIR)  dir_q  <= wbit0_i;
        end
    end

    always_comb begin
        unique case (idx_i)
            IDX_MODVER:  rdata_o = MOD_VERSION;
            ST_IDX_FIFO: rdata_o = fifo_status_i;
            ST_IDX_CHAN: rdata_o = {{(DATA_W-1){1'b0}}, chan_q};
            ST_IDX_DIR:  rdata_o = {{(DATA_W-1){1'b0}}, dir_q};
            default:     rdata_o = '0;
        endcase
    end

    assign chan_o = chan_q;
    assign dir_o  = dir_q;

    // R10: channel select only moves on a write to its own index
    a_r10_chan_hold: assert property (@(posedge clk) disable iff (rst)
        !(we_i && idx_i == ST_IDX_CHAN) |=> $stable(chan_q));
endmodule

// File: rtl/cmdreg_spi_slave.sv
module cmdreg_spi_slave
    import cmdreg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] SYS_MOD_VER = 8'h01,
    parameter logic [7:0] SYS_VERSION = 8'h01,
    parameter logic [7:0] MANUF_ID    = 8'h1E,
    parameter logic [7:0] IO_MOD_VER  = 8'h01,
    parameter logic [7:0] STR_MOD_VER = 8'h01
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [7:0] err_status_i,
    output logic       dbg_fifo_push_o,
    output logic       dbg_fifo_pull_o,
    output logic       dbg_stream_o,
    output logic [7:0] tx_gap_o,
    output logic [1:0] io_dbg_mode_o,
    output logic [2:0] rf_path_o,
    output logic [1:0] led_o,
    input  logic [3:0] cfg_i,
    input  logic       button_i,
    output logic [7:0] exp_dir_o,
    output logic [7:0] exp_val_o,
    input  logic [7:0] fifo_status_i,
    output logic       chan_sel_o,
    output logic       dir_sel_o
);
    logic [2:0]        pins_s;
    cmd_t              cmd;
    logic              wr;
    logic [DATA_W-1:0] wdata, rd_mux;
    logic [DATA_W-1:0] rd_sys, rd_io, rd_str;
    logic [2:0]        sys_dbg;

    // pin order: {sclk, cs_n, mosi}; chip select resets inactive (high)
    cmdreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({spi_sclk, spi_cs_n, spi_mosi}),
        .q_o (pins_s)
    );

    cmdreg_spi_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[2]),
        .cs_n_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .rd_data_i (rd_mux),
        .cmd_o     (cmd),
        .wr_o      (wr),
        .wdata_o   (wdata),
        .miso_o    (spi_miso)
    );

    cmdreg_sys_regs #(
        .MOD_VERSION (SYS_MOD_VER),
        .SYS_VERSION (SYS_VERSION),
        .MANUF_ID    (MANUF_ID)
    ) u_sys (
        .clk          (clk),
        .rst          (rst),
        .we_i         (wr && cmd.module_sel == MOD_SYS),
        .idx_i        (cmd.idx),
        .wdata_i      (wdata),
        .err_status_i (err_status_i),
        .rdata_o      (rd_sys),
        .dbg_o        (sys_dbg),
        .gap_o        (tx_gap_o)
    );

    cmdreg_io_regs #(.MOD_VERSION(IO_MOD_VER)) u_io (
        .clk        (clk),
        .rst        (rst),
        .we_i       (wr && cmd.module_sel == MOD_IO),
        .idx_i      (cmd.idx),
        .wdata_i    (wdata),
        .cfg_i      (cfg_i),
        .button_i   (button_i),
        .rdata_o    (rd_io),
        .dbg_mode_o (io_dbg_mode_o),
        .rf_path_o  (rf_path_o),
        .led_o      (led_o),
        .xdir_o     (exp_dir_o),
        .xval_o     (exp_val_o)
    );

    cmdreg_stream_regs #(.MOD_VERSION(STR_MOD_VER)) u_stream (
        .clk           (clk),
        .rst           (rst),
        .we_i          (wr && cmd.module_sel == MOD_STREAM),
        .idx_i         (cmd.idx),
        .wbit0_i       (wdata[0]),
        .fifo_status_i (fifo_status_i),
        .rdata_o       (rd_str),
        .chan_o        (chan_sel_o),
        .dir_o         (dir_sel_o)
    );

    always_comb begin
        unique case (cmd.module_sel)
            MOD_SYS:    rd_mux = rd_sys;
            MOD_IO:     rd_mux = rd_io;
            MOD_STREAM: rd_mux = rd_str;
            default:    rd_mux = '0;
        endcase
    end

    assign dbg_fifo_push_o = sys_dbg[0];
    assign dbg_fifo_pull_o = sys_dbg[1];
    assign dbg_stream_o    = sys_dbg[2];

    // R11: a reserved-module frame never feeds data to MISO
    a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        cmd.module_sel == MOD_RSVD |-> rd_mux == '0);
endmodule

// File: tb/cmdreg_spi_slave_tb.sv
module cmdreg_spi_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int TIMEOUT    = 190000;
    localparam logic [7:0] P_SYS_MOD = 8'h5C, P_SYS_VER = 8'h3B, P_MANUF = 8'hA7;
    localparam logic [7:0] P_IO_MOD  = 8'h62, P_STR_MOD = 8'h79;

    logic clk = 1'b0, rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [7:0] err_i = '0, fifo_i = '0;
    logic [3:0] cfg = '0;
    logic btn = 1'b0;
    logic dbg_push, dbg_pull, dbg_str, chan, dsel;
    logic [7:0] gap, xdir, xval;
    logic [1:0] iodbg, led;
    logic [2:0] rf;

    int checks = 0, failures = 0;
    bit done = 0;

    // bench model
    logic [2:0] m_dbg;  logic [7:0] m_gap;
    logic [1:0] m_iodbg; logic [2:0] m_rf; logic [1:0] m_led;
    logic [7:0] m_xdir, m_xval; logic m_chan, m_dir;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdreg_spi_slave #(
        .SYNC_STAGES(3), .SYS_MOD_VER(P_SYS_MOD), .SYS_VERSION(P_SYS_VER),
        .MANUF_ID(P_MANUF), .IO_MOD_VER(P_IO_MOD), .STR_MOD_VER(P_STR_MOD)
    ) u_dut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .err_status_i(err_i), .dbg_fifo_push_o(dbg_push),
        .dbg_fifo_pull_o(dbg_pull), .dbg_stream_o(dbg_str), .tx_gap_o(gap),
        .io_dbg_mode_o(iodbg), .rf_path_o(rf), .led_o(led), .cfg_i(cfg),
        .button_i(btn), .exp_dir_o(xdir), .exp_val_o(xval),
        .fifo_status_i(fifo_i), .chan_sel_o(chan), .dir_sel_o(dsel)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] c);
        logic [4:0] idx = c[4:0];
        case (c[6:5])
            2'd0: case (idx)
                0: return P_SYS_MOD;  1: return P_SYS_VER; 2: return P_MANUF;
                3: return err_i;      5: return {5'b0, m_dbg}; 6: return m_gap;
                default: return 8'h00;
            endcase
            2'd1: case (idx)
                0: return P_IO_MOD;  1: return {3'b0, m_rf, m_iodbg};
                2: return {btn, cfg, 1'b0, m_led};
                3: return m_xdir;    4: return m_xval;
                default: return 8'h00;
            endcase
            2'd2: case (idx)
                0: return P_STR_MOD; 1: return fifo_i;
                2: return {7'b0, m_chan}; 3: return {7'b0, m_dir};
                default: return 8'h00;
            endcase
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] c, input logic [7:0] d);
        if (c[6:5] == 2'd0) begin
            if (c[4:0] == 5) m_dbg = d[2:0];
            if (c[4:0] == 6) m_gap = d;
        end else if (c[6:5] == 2'd1) begin
            if (c[4:0] == 1) begin
                m_iodbg = d[1:0];
                if (d[4:2] <= 3'd5) m_rf = d[4:2];
            end
            if (c[4:0] == 2) m_led = d[1:0];
            if (c[4:0] == 3) m_xdir = d;
            if (c[4:0] == 4) m_xval = d;
        end else if (c[6:5] == 2'd2) begin
            if (c[4:0] == 2) m_chan = d[0];
            if (c[4:0] == 3) m_dir = d[0];
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shifts nbits of tx MSB first; rx captures the first 16 MISO bits
    task automatic spi_frame(input logic [31:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        cs_n = 1'b0;
        wait_cyc(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[31-i];
            wait_cyc(HALF);
            if (i < 16) rx[15-i] = miso;
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
        end
        wait_cyc(HALF);
        cs_n = 1'b1;
        wait_cyc(2*HALF);
    endtask

    task automatic check_ports(input string tag);
        check({tag, " R6 dbg"}, {dbg_str, dbg_pull, dbg_push}, m_dbg);
        check({tag, " R6 gap"}, gap, m_gap);
        check({tag, " R7 mode"}, {rf, iodbg}, {m_rf, m_iodbg});
        check({tag, " R8 led"}, led, m_led);
        check({tag, " R9 exp"}, {xdir, xval}, {m_xdir, m_xval});
        check({tag, " R10 stream"}, {chan, dsel}, {m_chan, m_dir});
        check({tag, " R1 miso idle"}, miso, 1'b0);
    endtask

    task automatic xfer(input string tag, input logic [7:0] c, input logic [7:0] d);
        logic [15:0] rx;
        logic [7:0] e = exp_read(c);
        spi_frame({c, d, 16'h0}, 16, rx);
        check({tag, " R1 cmd-byte miso"}, rx[15:8], 8'h00);
        if (!c[7]) check({tag, " R3 read data"}, rx[7:0], e);
        else model_write(c, d);
        check_ports(tag);
    endtask

    initial begin
        logic [15:0] rx;
        void'($urandom(32'd20240611));
        m_dbg = 0; m_gap = 0; m_iodbg = 0; m_rf = 0; m_led = 0;
        m_xdir = 0; m_xval = 0; m_chan = 0; m_dir = 0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
        check_ports("R12 reset");

        // R5 version and ID constants
        xfer("R5 sys ver0", 8'h00, 8'h00);
        xfer("R5 sys ver1", 8'h01, 8'h00);
        xfer("R5 manuf", 8'h02, 8'h00);
        xfer("R5 io ver", 8'h20, 8'h00);
        xfer("R5 str ver", 8'h40, 8'h00);
        // R6 system registers
        xfer("R6 gap wr", 8'h86, 8'h5A);
        xfer("R6 gap rd", 8'h06, 8'h00);
        err_i = 8'hC3;
        xfer("R6 err wr", 8'h83, 8'h11);
        xfer("R6 err rd", 8'h03, 8'h00);
        xfer("R6 dbg wr", 8'h85, 8'hFD);
        xfer("R6 dbg rd", 8'h05, 8'h00);
        // R7 RF path legality
        xfer("R7 mode wr", 8'hA1, 8'h17);
        xfer("R7 mode bad", 8'hA1, 8'h1A);
        check("R7 rf kept", rf, 3'd5);
        xfer("R7 mode rd", 8'h21, 8'h00);
        // R8 digital register
        cfg = 4'hA; btn = 1'b1;
        xfer("R8 dig wr", 8'hA2, 8'hFF);
        xfer("R8 dig rd", 8'h22, 8'h00);
        // R9, R10
        xfer("R9 xdir wr", 8'hA3, 8'h3C);
        xfer("R9 xdir rd", 8'h23, 8'h00);
        fifo_i = 8'h96;
        xfer("R10 fifo wr", 8'hC1, 8'h00);
        xfer("R10 fifo rd", 8'h41, 8'h00);
        xfer("R10 chan wr", 8'hC2, 8'hFF);
        xfer("R10 chan rd", 8'h42, 8'h00);
        // R11 reserved module and undefined indices
        xfer("R11 rsvd wr", 8'hE6, 8'h77);
        xfer("R11 rsvd rd", 8'h66, 8'h00);
        xfer("R11 undef wr", 8'h9F, 8'h55);
        xfer("R11 undef rd", 8'h07, 8'h00);
        // R4 aborted frame: write gap cut after 10 bits
        spi_frame({8'h86, 8'hEE, 16'h0}, 10, rx);
        check("R4 abort keeps gap", gap, m_gap);
        // R13 extra clocks after 16 bits: second command must not land
        spi_frame({8'hA4, 8'h81, 8'hA4, 8'h7E}, 32, rx);
        model_write(8'hA4, 8'h81);
        check("R13 xval single write", xval, 8'h81);
        check_ports("R13");

        // R2 random mix
        for (int n = 0; n < 220; n++) begin
            logic [7:0] c, d;
            c = 8'($urandom);
            if ($urandom % 4 != 0) c[4:0] = 5'($urandom % 8);
            d = 8'($urandom);
            err_i = 8'($urandom); fifo_i = 8'($urandom);
            cfg = 4'($urandom); btn = 1'($urandom);
            xfer("R2 random", c, d);
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (TIMEOUT) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule